// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a system timer for a processor subsystem. A 32-bit counter counts down by one each time a programmable prescaler has counted off p input clocks. Software programs a 32-bit start value as two 16-bit halves, picks the divisor p, and sets two control bits: one lets the counter run, the other picks repeating or single-run behaviour. A level interrupt goes high when the count runs out. Software drops the interrupt by writing any value to a dedicated clear location.

In single-run mode the counter stops at zero after the interrupt and stays there until software turns the timer off and on again. In repeating mode the start value is reloaded on each expiry, so the interrupt comes back every start-value times p clocks. Software reads the live count as two 16-bit halves through a synchronous register port. Read data is registered and shows up one cycle after the address. The block does not keep the two halves consistent with each other.

Top module: `cdt_timer`

## Requirements
- R1: After the synchronous reset the interrupt is low, the counter, the start value and the control bits are zero, and the divisor reads 1.
- R2: Byte offsets: start low 0x00, start high 0x04, divisor 0x10 and control 0x14 are writable and read back. Count low 0x08 and count high 0x0C are read-only. The clear location 0x18 and unmapped offsets read 0. Control bit 1 is run and bit 0 is repeat. Control bits 15..2 read 0. Read data appears on rdata in the cycle after the address is presented.
- R3: A control write that sets bit 1 while the timer is stopped copies the start value into the counter and restarts the prescaler. The first decrement happens p clocks after that write.
- R4: While running with a divisor p of 1 or more, the counter drops by exactly one every p clocks.
- R5: A tick that finds the count at 1 or 0 is an expiry and sets the interrupt. In single-run mode the counter then holds 0 and raises no further interrupt until the timer is restarted.
- R6: In repeating mode an expiry reloads the start value and counting goes on. The interrupt recurs every start-value times p clocks.
- R7: A write of any data to offset 0x18 clears the interrupt on the next cycle. If an expiry happens in the same cycle as that write, the interrupt stays high.
- R8: A divisor of 0 freezes the prescaler, and the counter does not move. Writing a nonzero divisor lets counting resume.
- R9: With the run bit cleared, the counter holds its value. Writes to the start value or the divisor do not change the count.
- R10: The two count halves can each be read on their own at 0x08 and 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for the previous cycle's address |
| irq | output | 1 | Level interrupt on expiry |

## Verification
The bench runs the count in single-run mode with divisor 3, in repeating mode with divisor 2, and in repeating mode with divisor 1. This separates a decrement that comes one clock early or late from a wrong reload, and it shows whether the counter stops or wraps after expiry. A clear write timed onto an expiry edge, and others timed one edge away from it, separate set-wins priority from plain clearing. A stop in the middle of a count with later start-value and divisor writes, a zero divisor, and a start value that borrows across the halves separate a held counter from a stalled one, and show whether the high half follows the low half.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_START_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT_LO = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_DIVISOR  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CONTROL  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CLR  = 5'h18;
  localparam int unsigned       OFS_STRIDE   = 4;

  localparam int unsigned CTL_RUN_BIT    = 1;
  localparam int unsigned CTL_REPEAT_BIT = 0;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] divisor,
  output logic          tick
);
  logic [PW-1:0] phase_q;
  logic          div_ok;

  assign div_ok = (divisor != '0);
  assign tick   = run && div_ok && (phase_q >= divisor - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run && div_ok) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

  // R8: zero divisor leaves the prescaler frozen
  p_zero_div_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0 && !restart) |=> $stable(phase_q));

  // R3: restart puts the phase back to its origin
  p_restart_phase_r3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          enable,
  input  logic          periodic,
  input  logic          tick,
  input  logic [CW-1:0] preload,
  output logic [CW-1:0] count,
  output logic          run,
  output logic          zero_evt
);
  logic [CW-1:0] count_q;
  logic          spent_q;
  logic          last_step;

  assign run       = enable && !spent_q;
  assign last_step = (count_q <= CW'(1));
  assign zero_evt  = tick && last_step;
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      spent_q <= 1'b0;
    end else if (start) begin
      count_q <= preload;
      spent_q <= 1'b0;
    end else if (tick) begin
      if (last_step) begin
        if (periodic) begin
          count_q <= preload;
        end else begin
          count_q <= '0;
          spent_q <= 1'b1;
        end
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  // R3: enabling copies the start value
  p_start_loads_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (count_q == $past(preload)));

  // R4: ordinary tick lowers the count by one
  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && !last_step) |=> (count_q == $past(count_q) - 1'b1));

  // R5: spent single-run counter stays at zero
  p_oneshot_rests_r5: assert property (@(posedge clk) disable iff (rst)
    (spent_q && !start) |=> (count_q == '0));

  // R6: repeating expiry reloads
  p_periodic_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && periodic && !start) |=> (count_q == $past(preload)));

  // R9: stopped counter holds
  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !start) |=> $stable(count_q));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned CW        = 32,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     count,
  input  logic              zero_evt,
  output logic [DW-1:0]     rdata,
  output logic [CW-1:0]     preload,
  output logic [DW-1:0]     divisor,
  output logic              enable,
  output logic              periodic,
  output logic              start,
  output logic              irq
);
  localparam int unsigned NH = CW / DW;

  logic [DW-1:0] start_q [NH];
  logic [DW-1:0] div_q;
  logic          run_q;
  logic          rep_q;
  logic          irq_q;
  logic [DW-1:0] rd_mux;
  logic          clr_hit;

  for (genvar h = 0; h < NH; h++) begin : g_start_half
    always_ff @(posedge clk) begin
      if (rst) begin
        start_q[h] <= '0;
      end else if (wr_en && addr == ADDR_W'(OFS_START_LO + OFS_STRIDE * h)) begin
        start_q[h] <= wdata;
      end
    end
    assign preload[h*DW +: DW] = start_q[h];
  end

  assign start   = wr_en && (addr == OFS_CONTROL) && wdata[CTL_RUN_BIT] && !run_q;
  assign clr_hit = wr_en && (addr == OFS_IRQ_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DW'(DIV_RESET);
      run_q <= 1'b0;
      rep_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFS_DIVISOR) div_q <= wdata;
      if (addr == OFS_CONTROL) begin
        run_q <= wdata[CTL_RUN_BIT];
        rep_q <= wdata[CTL_REPEAT_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (zero_evt) irq_q <= 1'b1;
    else if (clr_hit)  irq_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    for (int h = 0; h < NH; h++) begin
      if (addr == ADDR_W'(OFS_START_LO + OFS_STRIDE * h)) rd_mux = start_q[h];
      if (addr == ADDR_W'(OFS_COUNT_LO + OFS_STRIDE * h)) rd_mux = count[h*DW +: DW];
    end
    if (addr == OFS_DIVISOR) rd_mux = div_q;
    if (addr == OFS_CONTROL) begin
      rd_mux[CTL_RUN_BIT]    = run_q;
      rd_mux[CTL_REPEAT_BIT] = rep_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign divisor  = div_q;
  assign enable   = run_q;
  assign periodic = rep_q;
  assign irq      = irq_q;

  // R7: expiry sets the interrupt even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> irq_q);

  // R7: a lone clear write drops it
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !zero_evt) |=> !irq_q);

  // R2: reserved control bits read zero
  p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    (addr == OFS_CONTROL) |=> (rdata[DW-1:2] == '0));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned DW        = 16,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [4:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] preload;
  logic [CW-1:0] count;
  logic [DW-1:0] divisor;
  logic          enable;
  logic          periodic;
  logic          start;
  logic          run;
  logic          tick;
  logic          zero_evt;

  cdt_regs #(.DW(DW), .CW(CW), .DIV_RESET(DIV_RESET)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .count    (count),
    .zero_evt (zero_evt),
    .rdata    (rdata),
    .preload  (preload),
    .divisor  (divisor),
    .enable   (enable),
    .periodic (periodic),
    .start    (start),
    .irq      (irq)
  );

  cdt_prescale #(.PW(DW)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (start),
    .divisor (divisor),
    .tick    (tick)
  );

  cdt_counter #(.CW(CW)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .enable   (enable),
    .periodic (periodic),
    .tick     (tick),
    .preload  (preload),
    .count    (count),
    .run      (run),
    .zero_evt (zero_evt)
  );
endmodule

// File: tb/cdt_timer_tb_top.sv
`timescale 1ns/1ps
module cdt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'h08;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int    checks = 0;
  int    fails = 0;
  bit    ended = 1'b0;
  string phase_req = "R1";

  localparam logic [4:0] A_SLO = 5'h00, A_SHI = 5'h04, A_VLO = 5'h08, A_VHI = 5'h0C;
  localparam logic [4:0] A_DIV = 5'h10, A_CTL = 5'h14, A_CLR = 5'h18;

  always #2.5 clk = ~clk;

  cdt_timer dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .irq(irq));

  // behavioural reference, advanced on every rising edge
  logic [31:0] m_cnt, m_start;
  logic [15:0] m_div, m_rd;
  bit          m_run, m_rep, m_spent, m_irq;
  int          m_phase;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_start = 0; m_div = 1; m_rd = 0;
      m_run = 0; m_rep = 0; m_spent = 0; m_irq = 0; m_phase = 0;
    end else begin
      bit go, tk, expire;
      case (addr)
        A_SLO: m_rd = m_start[15:0];
        A_SHI: m_rd = m_start[31:16];
        A_VLO: m_rd = m_cnt[15:0];
        A_VHI: m_rd = m_cnt[31:16];
        A_DIV: m_rd = m_div;
        A_CTL: m_rd = {14'd0, m_run, m_rep};
        default: m_rd = 0;
      endcase
      go     = wr_en && addr == A_CTL && wdata[1] && !m_run;
      tk     = m_run && !m_spent && m_div != 0 && (m_phase + 1 >= int'(m_div));
      expire = tk && m_cnt <= 1;
      if (go) begin
        m_cnt = m_start; m_phase = 0; m_spent = 0;
      end else if (m_run && !m_spent && m_div != 0) begin
        if (tk) begin
          m_phase = 0;
          if (expire) begin
            if (m_rep) m_cnt = m_start;
            else begin m_cnt = 0; m_spent = 1; end
          end else m_cnt = m_cnt - 1;
        end else m_phase++;
      end
      if (expire) m_irq = 1;
      else if (wr_en && addr == A_CLR) m_irq = 0;
      if (wr_en) begin
        if (addr == A_SLO) m_start[15:0] = wdata;
        if (addr == A_SHI) m_start[31:16] = wdata;
        if (addr == A_DIV) m_div = wdata;
        if (addr == A_CTL) begin m_run = wdata[1]; m_rep = wdata[0]; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk({phase_req, " model irq"}, {31'd0, irq}, {31'd0, m_irq});
      chk({phase_req, " model rdata"}, {16'd0, rdata}, {16'd0, m_rd});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = A_VLO;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata; addr = A_VLO;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v, a0, b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    phase_req = "R1";
    chk("R1 irq", {31'd0, irq}, 0);
    rd(A_CTL, v); chk("R1 control", {16'd0, v}, 0);
    rd(A_DIV, v); chk("R1 divisor", {16'd0, v}, 1);
    rd(A_VLO, v); chk("R1 count", {16'd0, v}, 0);

    // R2 map and readback
    phase_req = "R2";
    wr(A_SLO, 16'hBEEF); wr(A_SHI, 16'h0012);
    rd(A_SLO, v); chk("R2 start lo", {16'd0, v}, 32'hBEEF);
    rd(A_SHI, v); chk("R2 start hi", {16'd0, v}, 32'h0012);
    wr(A_CTL, 16'hFFFC);
    rd(A_CTL, v); chk("R2 control reserved", {16'd0, v}, 0);
    rd(A_CLR, v); chk("R2 clear reads zero", {16'd0, v}, 0);

    // R3 R4 R5 single run, divisor 3, start 5
    phase_req = "R5";
    wr(A_SLO, 16'd5); wr(A_SHI, 16'd0); wr(A_DIV, 16'd3);
    wr(A_CTL, 16'h0002);
    idle(3); chk("R3 no early decrement", {16'd0, rdata}, 5);
    idle(1); chk("R4 first decrement", {16'd0, rdata}, 4);
    idle(10); chk("R5 irq before expiry", {31'd0, irq}, 0);
    idle(1); chk("R5 irq on expiry", {31'd0, irq}, 1);
    idle(10); chk("R5 count rests at zero", {16'd0, rdata}, 0);
    phase_req = "R7";
    wr(A_CLR, 16'h1234); chk("R7 clear by any data", {31'd0, irq}, 0);
    idle(30); chk("R5 no second irq", {31'd0, irq}, 0);

    // R6 repeating, divisor 2, start 4
    phase_req = "R6";
    wr(A_CTL, 16'h0000); wr(A_SLO, 16'd4); wr(A_DIV, 16'd2);
    wr(A_CTL, 16'h0003);
    idle(7); chk("R6 irq before first expiry", {31'd0, irq}, 0);
    idle(1); chk("R6 first expiry", {31'd0, irq}, 1);
    wr(A_CLR, 16'h0); chk("R6 cleared", {31'd0, irq}, 0);
    idle(6); chk("R6 quiet mid period", {31'd0, irq}, 0);
    idle(1); chk("R6 second expiry", {31'd0, irq}, 1);

    // R7 clear colliding with expiry, divisor 1, start 2
    phase_req = "R7";
    wr(A_CTL, 16'h0000); wr(A_SLO, 16'd2); wr(A_DIV, 16'd1);
    wr(A_CTL, 16'h0003);
    idle(2);
    wr(A_CLR, 16'h0); chk("R7 clear off expiry", {31'd0, irq}, 0);
    wr(A_CLR, 16'h0); chk("R7 expiry beats clear", {31'd0, irq}, 1);
    wr(A_CLR, 16'h0); chk("R7 clear after collision", {31'd0, irq}, 0);

    // R9 hold while stopped
    phase_req = "R9";
    wr(A_CTL, 16'h0000); wr(A_CLR, 16'h0); wr(A_SLO, 16'd100);
    wr(A_CTL, 16'h0002);
    idle(10);
    wr(A_CTL, 16'h0000);
    rd(A_VLO, a0); chk("R9 value at stop", {16'd0, a0}, 89);
    wr(A_SLO, 16'd7); wr(A_DIV, 16'd5);
    idle(20);
    rd(A_VLO, b0); chk("R9 held after writes", {16'd0, b0}, 89);

    // R8 zero divisor
    phase_req = "R8";
    wr(A_DIV, 16'd0); wr(A_SLO, 16'd50);
    wr(A_CTL, 16'h0002);
    idle(20);
    rd(A_VLO, v); chk("R8 frozen count", {16'd0, v}, 50);
    chk("R8 no irq", {31'd0, irq}, 0);
    wr(A_DIV, 16'd1);
    idle(60); chk("R8 resumes and expires", {31'd0, irq}, 1);

    // R10 halves with borrow, start 0x0001_0002, divisor 1
    phase_req = "R10";
    wr(A_CTL, 16'h0000); wr(A_CLR, 16'h0);
    wr(A_SLO, 16'd2); wr(A_SHI, 16'd1);
    wr(A_CTL, 16'h0002);
    idle(2);
    wr(A_CTL, 16'h0000);
    rd(A_VLO, v); chk("R10 low half", {16'd0, v}, 32'hFFFF);
    rd(A_VHI, v); chk("R10 high half", {16'd0, v}, 0);

    idle(2);
    finish_run();
  end
endmodule